// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block detects pin events for one bank of general-purpose pins. The bank is split into ports of eight pins each, four ports by default. Each pin has a three-bit trigger code that selects one of five modes: level high, level low, rising edge, falling edge or both edges. A detected event sets a sticky bit in the port's status register. A port enable register decides which status bits reach the single bank interrupt line.

Software acknowledges a status bit by writing a one to the clear register at that bit position. Status, enable and trigger registers also accept masked writes, which change only the selected pins. The pin inputs must already be synchronised to the block clock. The register bus is a single-cycle write strobe, and read data comes combinationally from the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held, and after it is released with all pins high, every status, enable and trigger register reads 0 and `irq` is low.
- R2: With trigger code 0b001 (bits {b+16, b+8, b} = {both, edge, polarity}), the status bit of pin b is set on every cycle that the pin is high. This includes the cycle that a clear is written.
- R3: With trigger code 0b000, the status bit of pin b is set on every cycle that the pin is low.
- R4: With code 0b011, a pin that is high in the current cycle and was low in the previous cycle sets its status bit. The register update appears one clock later.
- R5: With code 0b010, a pin that is low in the current cycle and was high in the previous cycle sets its status bit.
- R6: With code 0b110, any change of a pin from one cycle to the next sets its status bit.
- R7: Writing the clear register (offset 0x70) clears each status bit written as 1. Bits written as 0 keep their value.
- R8: When a clear of a bit and a new event on that pin fall in the same cycle, the status bit stays set.
- R9: Masked writes change only the pins selected by the mask. At offsets 0xC0 (status) and 0xD0 (enable), wdata[15:8] is the mask and wdata[7:0] the data. At offset 0xE0 (trigger), wdata[31:24] is the mask and wdata[23:0] holds the three lanes, and a selected pin takes all three of its bits.
- R10: `irq` is the OR, over all ports and pins, of status AND enable. A direct write of 0 to a port's enable register removes that port's contribution.
- R11: The register offset is 0x40 for status, 0x50 for enable, 0x60 for trigger and 0x70 for clear. The port number is addr[3:2] and addr[1:0] must be 0. Reads return status, enable and trigger zero-extended, and the clear offset reads 0.
- R12: A direct write to status (0x40) or enable (0x50) replaces the whole port value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 32 | Synchronised pin levels, pin p*8+b is port p bit b |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Bank interrupt |

## Verification
A software clear and a new pin event can land on the same status bit in the same cycle. The bench provokes this by holding a rising-edge pin low and then, on one clock edge, writing the clear and raising the pin. It judges the result by reading the status back: the bit must still be set, and a clear written with no event must then remove it. The level-mode variant of this collision is covered by the vector table, where a clear written while the active level is present must leave the bit set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Decoded register function of a bus address
    typedef enum logic [2:0] {
        FN_NONE = 3'd0,
        FN_STA  = 3'd1,
        FN_ENB  = 3'd2,
        FN_LVL  = 3'd3,
        FN_CLR  = 3'd4,
        FN_MSTA = 3'd5,
        FN_MENB = 3'd6,
        FN_MLVL = 3'd7
    } gpio_fn_e;

    // Upper address nibble of each register group
    localparam logic [3:0] NIB_STA  = 4'h4;
    localparam logic [3:0] NIB_ENB  = 4'h5;
    localparam logic [3:0] NIB_LVL  = 4'h6;
    localparam logic [3:0] NIB_CLR  = 4'h7;
    localparam logic [3:0] NIB_MSTA = 4'hC;
    localparam logic [3:0] NIB_MENB = 4'hD;
    localparam logic [3:0] NIB_MLVL = 4'hE;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    output gpio_fn_e          fn,
    output logic [1:0]        port_idx,
    output logic [NPORTS-1:0] wr_sel
);

    logic addr_ok;

    always_comb begin
        port_idx = bus_addr[3:2];
        addr_ok  = (bus_addr[1:0] == 2'b00) && (int'(port_idx) < NPORTS);
        fn       = FN_NONE;
        if (addr_ok) begin
            case (bus_addr[7:4])
                NIB_STA:  fn = FN_STA;
                NIB_ENB:  fn = FN_ENB;
                NIB_LVL:  fn = FN_LVL;
                NIB_CLR:  fn = FN_CLR;
                NIB_MSTA: fn = FN_MSTA;
                NIB_MENB: fn = FN_MENB;
                NIB_MLVL: fn = FN_MLVL;
                default:  fn = FN_NONE;
            endcase
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_sel
        assign wr_sel[p] = bus_we && (fn != FN_NONE) && (int'(port_idx) == p);
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect (
    input  logic       cur,
    input  logic       prev,
    input  logic [2:0] code,   // {both, edge, polarity}
    output logic       evt
);

    logic rise;
    logic fall;

    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (!code[1]) begin
            evt = code[0] ? cur : ~cur;
        end else if (code[2]) begin
            evt = rise | fall;
        end else begin
            evt = code[0] ? rise : fall;
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel,
    input  gpio_fn_e        fn,
    input  logic [4*PW-1:0] wdata,
    input  logic [PW-1:0]   cur,
    input  logic [PW-1:0]   prev,
    output logic [PW-1:0]   sta,
    output logic [PW-1:0]   enb,
    output logic [3*PW-1:0] lvl
);

    localparam int LW = 3 * PW;

    typedef struct packed {
        logic [PW-1:0] sta;
        logic [PW-1:0] enb;
        logic [LW-1:0] lvl;
    } port_state_t;

    port_state_t st_d;
    port_state_t st_q;

    logic [PW-1:0] evt;
    logic [PW-1:0] msk_lo;
    logic [PW-1:0] msk_hi;

    for (genvar b = 0; b < PW; b++) begin : g_pin
        gpio_irq_detect u_det (
            .cur  (cur[b]),
            .prev (prev[b]),
            .code ({st_q.lvl[2*PW+b], st_q.lvl[PW+b], st_q.lvl[b]}),
            .evt  (evt[b])
        );
    end

    always_comb begin
        st_d   = st_q;
        msk_lo = wdata[PW +: PW];
        msk_hi = wdata[3*PW +: PW];
        if (wr_sel) begin
            case (fn)
                FN_STA:  st_d.sta = wdata[PW-1:0];
                FN_ENB:  st_d.enb = wdata[PW-1:0];
                FN_LVL:  st_d.lvl = wdata[LW-1:0];
                FN_CLR:  st_d.sta = st_q.sta & ~wdata[PW-1:0];
                FN_MSTA: st_d.sta = (st_q.sta & ~msk_lo) | (wdata[PW-1:0] & msk_lo);
                FN_MENB: st_d.enb = (st_q.enb & ~msk_lo) | (wdata[PW-1:0] & msk_lo);
                FN_MLVL: begin
                    for (int l = 0; l < 3; l++) begin
                        st_d.lvl[l*PW +: PW] = (st_q.lvl[l*PW +: PW] & ~msk_hi)
                                             | (wdata[l*PW +: PW] & msk_hi);
                    end
                end
                default: ;
            endcase
        end
        // new events take precedence over any clear in the same cycle
        st_d.sta = st_d.sta | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sta = st_q.sta;
    assign enb = st_q.enb;
    assign lvl = st_q.lvl;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS*PW-1:0] pin_lvl,
    input  logic                 bus_we,
    input  logic [7:0]           bus_addr,
    input  logic [4*PW-1:0]      bus_wdata,
    output logic [4*PW-1:0]      bus_rdata,
    output logic                 irq
);

    localparam int NPINS = NPORTS * PW;
    localparam int DW    = 4 * PW;
    localparam int LW    = 3 * PW;

    logic [NPINS-1:0] prev_d;
    logic [NPINS-1:0] prev_q;

    gpio_fn_e          fn;
    logic [1:0]        port_idx;
    logic [NPORTS-1:0] wr_sel;

    logic [NPINS-1:0]    sta_all;
    logic [NPINS-1:0]    enb_all;
    logic [NPORTS*LW-1:0] lvl_all;

    gpio_irq_decode #(.NPORTS(NPORTS)) u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .fn       (fn),
        .port_idx (port_idx),
        .wr_sel   (wr_sel)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        gpio_irq_port #(.PW(PW)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (wr_sel[p]),
            .fn     (fn),
            .wdata  (bus_wdata),
            .cur    (pin_lvl[p*PW +: PW]),
            .prev   (prev_q[p*PW +: PW]),
            .sta    (sta_all[p*PW +: PW]),
            .enb    (enb_all[p*PW +: PW]),
            .lvl    (lvl_all[p*LW +: LW])
        );
    end

    always_comb begin
        prev_d = pin_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (int'(port_idx) == p) begin
                case (fn)
                    FN_STA, FN_MSTA: bus_rdata = {{(DW-PW){1'b0}}, sta_all[p*PW +: PW]};
                    FN_ENB, FN_MENB: bus_rdata = {{(DW-PW){1'b0}}, enb_all[p*PW +: PW]};
                    FN_LVL, FN_MLVL: bus_rdata = {{(DW-LW){1'b0}}, lvl_all[p*LW +: LW]};
                    default:         bus_rdata = '0;
                endcase
            end
        end
    end

    assign irq = |(sta_all & enb_all);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int NPORTS = 4,
    parameter int PW     = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [7:0]             bus_addr,
    input logic [4*PW-1:0]        bus_wdata,
    input logic                   irq,
    input logic [NPORTS*PW-1:0]   sta_all,
    input logic [NPORTS*PW-1:0]   enb_all,
    input logic [NPORTS*3*PW-1:0] lvl_all
);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enb_all == '0) |-> !irq);

    assert_sta_drop_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (($past(sta_all) & ~sta_all) == '0));

    assert_lvl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(lvl_all));

    assert_enb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(enb_all));

    assert_enb_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h50 && bus_wdata == '0) |=> (enb_all[PW-1:0] == '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPORTS(NPORTS), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .sta_all   (sta_all),
    .enb_all   (enb_all),
    .lvl_all   (lvl_all)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = '1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {req[3:0], 1'b0, expected, cur, prev, trigger code for pin 0}
    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000001},  // R2 low stays low
        {4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 24'h000001},  // R2 goes high
        {4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 24'h000001},  // R2 high during clear
        {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 24'h000000},  // R3 high stays high
        {4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 24'h000000},  // R3 goes low
        {4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 24'h000101},  // R4 rise
        {4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 24'h000101},  // R4 fall ignored
        {4'd4, 1'b0, 1'b0, 1'b1, 1'b1, 24'h000101},  // R4 steady high
        {4'd5, 1'b0, 1'b1, 1'b0, 1'b1, 24'h000100},  // R5 fall
        {4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000100},  // R5 rise ignored
        {4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 24'h010100},  // R6 rise
        {4'd6, 1'b0, 1'b1, 1'b0, 1'b1, 24'h010100},  // R6 fall
        {4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 24'h010100}   // R6 steady
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [3:0]  rq;

        // R1 during reset
        repeat (2) @(negedge clk);
        rd(8'h40, v);
        check("R1 sta in reset", v, 32'h0);
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            rd(8'h40 + 8'(p*4), v); check("R1 sta", v, 32'h0);
            rd(8'h50 + 8'(p*4), v); check("R1 enb", v, 32'h0);
            rd(8'h60 + 8'(p*4), v); check("R1 lvl", v, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);

        // vector table on port 1 pin 5
        for (int i = 0; i < NV; i++) begin
            rq = VEC[i][31:28];
            wr(8'h64, VEC[i][23:0] << 5);
            pin_lvl[13] = VEC[i][24];
            repeat (2) @(negedge clk);
            wr(8'h74, 32'hFF);
            pin_lvl[13] = VEC[i][25];
            @(negedge clk);
            rd(8'h44, v);
            check($sformatf("R%0d vector %0d", rq, i), {31'b0, v[5]}, {31'b0, VEC[i][26]});
        end
        pin_lvl[13] = 1'b1;
        wr(8'h64, 32'h0);
        wr(8'h74, 32'hFF);

        // R11 and R12 addressing and direct writes
        wr(8'h58, 32'hA5);
        rd(8'h58, v); check("R12 enb direct", v, 32'hA5);
        rd(8'h50, v); check("R11 other port", v, 32'h0);
        rd(8'h78, v); check("R11 clr reads 0", v, 32'h0);

        // R9 masked writes
        wr(8'hD8, 32'h0F03);
        rd(8'h58, v); check("R9 enb masked", v, 32'hA3);
        wr(8'h68, 32'h00FF00);
        wr(8'hE8, {8'h01, 24'h000101});
        rd(8'h68, v); check("R9 lvl masked", v, 32'h00FF01);
        wr(8'hC8, 32'h8080);
        rd(8'h48, v); check("R9 sta masked", v, 32'h80);

        // R10 interrupt
        check("R10 irq on", {31'b0, irq}, 32'h1);
        wr(8'h58, 32'h0);
        check("R10 irq off after enb 0", {31'b0, irq}, 32'h0);
        rd(8'h48, v); check("R10 sta kept", v, 32'h80);
        wr(8'h48, 32'h0);
        rd(8'h48, v); check("R12 sta direct 0", v, 32'h0);

        // R7 clear semantics
        wr(8'hC8, 32'hFF3C);
        wr(8'h78, 32'h00);
        rd(8'h48, v); check("R7 clear zero no effect", v, 32'h3C);
        wr(8'h78, 32'h04);
        rd(8'h48, v); check("R7 clear one bit", v, 32'h38);

        // R8 clear and rising event in the same cycle, port 3 pin 0
        wr(8'h6C, 32'h000101);
        pin_lvl[24] = 1'b0;
        repeat (2) @(negedge clk);
        rd(8'h4C, v); check("R8 no event on fall", v, 32'h0);
        bus_we = 1'b1;
        bus_addr = 8'h7C;
        bus_wdata = 32'h1;
        pin_lvl[24] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(8'h4C, v); check("R8 event wins over clear", v, 32'h1);
        wr(8'h7C, 32'h1);
        rd(8'h4C, v); check("R8 later clear", v, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule